// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block is a memory-mapped real-time clock. A prescaler divides the system clock down to one tick per second, and each tick advances a 32-bit seconds count. Software can preload the count at any time and program a 32-bit alarm value. When the count becomes equal to the alarm value, a raw interrupt flag sets. A mask bit gates that flag onto the interrupt output.

Once out of reset the count always runs. It cannot be paused, and the control word is fixed at "enabled". The alarm compares for exact equality. Because the 32-bit count wraps modulo 2^32, an alarm value below the present count fires after the count wraps past zero. Each write to the alarm or preload register arms the comparison once. After a match the flag is not raised again until software rearms it.

Registers sit in a 4 KiB window on a single-cycle bus. Writes are taken on the clock edge. Reads return combinationally while the select is high.

Top module: `secs_rtc`

## Requirements
- R1: The seconds count advances by exactly one every CLKS_PER_SEC clock cycles. Reading offset 0x00 returns the present count, and the count is 0 after reset.
- R2: A write to offset 0x08 makes the count equal to the written value in the following cycle, and offset 0x08 then reads that value back. The one-second phase restarts, so the count holds the loaded value for exactly CLKS_PER_SEC cycles.
- R3: Writes to offset 0x00 leave the count unchanged.
- R4: Offset 0x04 holds the alarm value, is readable and writable, and resets to 0. A write to offset 0x04 or offset 0x08 arms the comparison.
- R5: When the comparison is armed and the count equals the alarm value, the raw flag (offset 0x14, bit 0) is 1 from the next cycle on, and the comparison disarms. Equality is modulo 2^32, so an alarm value below the count fires after wraparound.
- R6: The mask is offset 0x10, bit 0, and resets to 0. Offset 0x18 bit 0 and the `irq` output equal raw AND mask, and they follow a mask write in the next cycle. `irq_rise` is high for one cycle when `irq` goes from 0 to 1.
- R7: A write of any nonzero value to offset 0x1C clears the raw flag, and with it the masked flag. A write of zero there has no effect, and offset 0x1C reads 0.
- R8: Offset 0x0C always reads 1, and writes to it neither stop nor alter the count.
- R9: Offsets outside 0x00 to 0x1C, and offsets that are not word aligned, read 0 and ignore writes. The single-bit registers read 0 in bits 31:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| irq | output | 1 | Masked interrupt level |
| irq_rise | output | 1 | One-cycle pulse when irq rises |

## Verification
The alarm is tested in several ways:
- An alarm a few seconds ahead of a fresh preload shows that the count and the compare agree.
- An alarm below the count after a preload near 0xFFFFFFFE shows that the compare wraps rather than doing a magnitude test.
- Idling past a match that has already been cleared shows that the comparison fires only once per arming.

Reads taken right after a preload written midway through a second show that the prescaler phase restarts rather than carrying over. Mask toggles applied while the raw flag is already set show that the level output and the rise pulse follow the mask and not only new matches.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned SEC_W = 32;

    typedef enum logic [2:0] {
        RG_COUNT  = 3'd0,
        RG_ALARM  = 3'd1,
        RG_PRELD  = 3'd2,
        RG_ENABLE = 3'd3,
        RG_MASK   = 3'd4,
        RG_RAW    = 3'd5,
        RG_MASKED = 3'd6,
        RG_ACK    = 3'd7
    } rtc_reg_e;

    typedef struct packed {
        logic             preload;
        logic             alarm;
        logic             mask;
        logic             ack;
        logic [SEC_W-1:0] data;
    } rtc_wr_t;

    function automatic logic [SEC_W-1:0] flag_word(input logic b);
        return {{(SEC_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CLKS_PER_SEC < 2) ? 1 : $clog2(CLKS_PER_SEC);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_SEC - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    input  logic             tick,
    output logic [SEC_W-1:0] count,
    output logic [SEC_W-1:0] preload_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            preload_q <= '0;
        end else if (load_en) begin
            count     <= load_val;
            preload_q <= load_val;
        end else if (tick) begin
            count     <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rtc_wr_t          wr,
    input  logic [SEC_W-1:0] count,
    output logic [SEC_W-1:0] alarm_q,
    output logic             mask_q,
    output logic             raw_q,
    output logic             masked,
    output logic             irq_rise,
    output logic             hit
);
    logic armed_q;
    logic masked_prev_q;

    assign hit      = armed_q && (count == alarm_q);
    assign masked   = raw_q & mask_q;
    assign irq_rise = masked & ~masked_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q       <= '0;
            mask_q        <= 1'b0;
            raw_q         <= 1'b0;
            armed_q       <= 1'b0;
            masked_prev_q <= 1'b0;
        end else begin
            if (wr.alarm) alarm_q <= wr.data;
            if (wr.mask)  mask_q  <= wr.data[0];
            if (wr.alarm || wr.preload) begin
                armed_q <= 1'b1;
            end else if (hit) begin
                armed_q <= 1'b0;
            end
            if (hit) begin
                raw_q <= 1'b1;
            end else if (wr.ack && (wr.data != '0)) begin
                raw_q <= 1'b0;
            end
            masked_prev_q <= masked;
        end
    end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 100_000_000,
    parameter int unsigned ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SEC_W-1:0]  bus_wdata,
    output logic [SEC_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              irq_rise
);
    logic             mapped;
    rtc_reg_e         reg_idx;
    rtc_wr_t          wr;
    logic             sec_tick;
    logic [SEC_W-1:0] sec_count;
    logic [SEC_W-1:0] preload_q;
    logic [SEC_W-1:0] alarm_q;
    logic             mask_q;
    logic             raw_q;
    logic             masked;
    logic             cmp_hit;

    assign mapped  = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);
    assign reg_idx = rtc_reg_e'(bus_addr[4:2]);

    always_comb begin
        wr         = '0;
        wr.data    = bus_wdata;
        if (bus_sel && bus_wr && mapped) begin
            wr.preload = (reg_idx == RG_PRELD);
            wr.alarm   = (reg_idx == RG_ALARM);
            wr.mask    = (reg_idx == RG_MASK);
            wr.ack     = (reg_idx == RG_ACK);
        end
    end

    rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (wr.preload),
        .tick    (sec_tick)
    );

    rtc_seconds u_secs (
        .clk       (clk),
        .rst       (rst),
        .load_en   (wr.preload),
        .load_val  (wr.data),
        .tick      (sec_tick),
        .count     (sec_count),
        .preload_q (preload_q)
    );

    rtc_alarm u_alarm (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .count    (sec_count),
        .alarm_q  (alarm_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .masked   (masked),
        .irq_rise (irq_rise),
        .hit      (cmp_hit)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && mapped) begin
            unique case (reg_idx)
                RG_COUNT:  bus_rdata = sec_count;
                RG_ALARM:  bus_rdata = alarm_q;
                RG_PRELD:  bus_rdata = preload_q;
                RG_ENABLE: bus_rdata = flag_word(1'b1);
                RG_MASK:   bus_rdata = flag_word(mask_q);
                RG_RAW:    bus_rdata = flag_word(raw_q);
                RG_MASKED: bus_rdata = flag_word(masked);
                RG_ACK:    bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = masked;
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              irq_rise,
    input logic [31:0]       count,
    input logic              raw,
    input logic              mask,
    input logic              hit
);
    logic in_map;
    logic wr_preload;
    logic wr_ack;

    assign in_map     = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);
    assign wr_preload = bus_sel && bus_wr && in_map && (bus_addr[4:2] == 3'd2);
    assign wr_ack     = bus_sel && bus_wr && in_map && (bus_addr[4:2] == 3'd7);

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_preload |=> (count == $past(count)) || (count == $past(count) + 32'd1));

    assert_preload_R2: assert property (@(posedge clk) disable iff (rst)
        wr_preload |=> (count == $past(bus_wdata)));

    assert_hit_sets_raw_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw);

    assert_mask_gates_R6: assert property (@(posedge clk) disable iff (rst)
        !mask |-> !irq);

    assert_rise_level_R6: assert property (@(posedge clk) disable iff (rst)
        irq_rise |-> irq);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && (bus_wdata != 32'd0) && !hit) |=> !raw);

    assert_enable_one_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && in_map && (bus_addr[4:2] == 3'd3)) |-> (bus_rdata == 32'd1));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !in_map) |-> (bus_rdata == 32'd0));
endmodule

bind secs_rtc secs_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .irq_rise  (irq_rise),
    .count     (sec_count),
    .raw       (raw_q),
    .mask      (mask_q),
    .hit       (cmp_hit)
);

// File: tb/tb_secs_rtc.sv
module tb_secs_rtc;
    localparam int CPS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [11:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        irq_rise;

    int errs   = 0;
    int checks = 0;

    always #2 clk = ~clk;

    secs_rtc #(.CLKS_PER_SEC(CPS), .ADDR_W(12)) dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .irq_rise(irq_rise)
    );

    // behavioural reference: time since last preload, alarm armed flag
    longint      m_cyc   = 0;
    logic [31:0] m_base  = '0;
    logic [31:0] m_alarm = '0;
    bit          m_mask = 0, m_raw = 0, m_armed = 0, m_prev = 0;

    function automatic logic [31:0] m_count();
        return m_base + 32'(m_cyc / CPS);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a[11:5] != 0 || a[1:0] != 0) return 32'd0;
        case (a[4:2])
            3'd0: return m_count();
            3'd1: return m_alarm;
            3'd2: return m_base;
            3'd3: return 32'd1;
            3'd4: return {31'd0, m_mask};
            3'd5: return {31'd0, m_raw};
            3'd6: return {31'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_base = '0; m_alarm = '0;
            m_mask = 0; m_raw = 0; m_armed = 0; m_prev = 0;
        end else begin
            bit hit_now;
            bit is_wr;
            hit_now = m_armed && (m_count() == m_alarm);
            is_wr   = sel && wr && addr[11:5] == 0 && addr[1:0] == 0;
            m_prev  = m_raw & m_mask;
            if (hit_now) m_armed = 0;
            if (hit_now) m_raw = 1;
            else if (is_wr && addr[4:2] == 3'd7 && wdata != 0) m_raw = 0;
            if (is_wr && addr[4:2] == 3'd1) begin m_alarm = wdata; m_armed = 1; end
            if (is_wr && addr[4:2] == 3'd4) m_mask = wdata[0];
            if (is_wr && addr[4:2] == 3'd2) begin
                m_base = wdata; m_cyc = 0; m_armed = 1;
            end else begin
                m_cyc++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the interrupt outputs (R6)
    always @(negedge clk) begin
        if (!rst) begin
            chk(irq == (m_raw & m_mask), "R6 irq level", {31'd0, irq}, {31'd0, m_raw & m_mask});
            chk(irq_rise == ((m_raw & m_mask) & ~m_prev), "R6 irq_rise pulse",
                {31'd0, irq_rise}, {31'd0, (m_raw & m_mask) & ~m_prev});
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_model(input logic [11:0] a, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(rdata == m_read(a), tag, rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel = 1'b0; wr = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_lit(12'h000, 32'd0, "R1 count after reset");
        rd_lit(12'h004, 32'd0, "R4 alarm after reset");
        rd_lit(12'h008, 32'd0, "R2 preload after reset");
        rd_lit(12'h00C, 32'd1, "R8 enable reads one");
        rd_lit(12'h010, 32'd0, "R6 mask after reset");
        rd_lit(12'h014, 32'd0, "R5 raw after reset");
        rd_lit(12'h018, 32'd0, "R6 masked after reset");

        // preload and counting
        bus_write(12'h008, 32'd100);
        rd_lit(12'h000, 32'd100, "R2 count holds preload value");
        rd_lit(12'h008, 32'd100, "R2 preload readback");
        idle(3 * CPS);
        rd_model(12'h000, "R1 count after seconds");

        // preload mid-second restarts the phase
        idle(2);
        bus_write(12'h008, 32'd500);
        rd_lit(12'h000, 32'd500, "R2 phase restarted, still 500");
        idle(CPS - 3);
        rd_lit(12'h000, 32'd500, "R2 last cycle at 500");
        rd_lit(12'h000, 32'd501, "R2 advanced after one second");

        // data write ignored
        bus_write(12'h000, 32'hDEAD_BEEF);
        rd_model(12'h000, "R3 count unaffected by data write");

        // control write ignored, count keeps running
        bus_write(12'h00C, 32'd0);
        rd_lit(12'h00C, 32'd1, "R8 enable still one");
        idle(2 * CPS);
        rd_model(12'h000, "R8 count still running");

        // alarm ahead, mask off
        bus_write(12'h008, 32'd1000);
        bus_write(12'h004, 32'd1002);
        rd_lit(12'h004, 32'd1002, "R4 alarm readback");
        idle(3 * CPS + 2);
        rd_lit(12'h014, 32'd1, "R5 raw set on match");
        rd_lit(12'h018, 32'd0, "R6 masked zero while mask off");
        bus_write(12'h010, 32'd1);
        rd_lit(12'h018, 32'd1, "R6 masked follows mask");
        rd_lit(12'h010, 32'd1, "R6 mask readback");

        // acknowledge
        bus_write(12'h01C, 32'd0);
        rd_lit(12'h014, 32'd1, "R7 zero ack has no effect");
        bus_write(12'h01C, 32'h8000_0000);
        rd_lit(12'h014, 32'd0, "R7 nonzero ack clears raw");
        rd_lit(12'h018, 32'd0, "R7 nonzero ack clears masked");
        rd_lit(12'h01C, 32'd0, "R7 ack reads zero");
        idle(2 * CPS);
        rd_lit(12'h014, 32'd0, "R5 no refire without rearm");

        // wraparound
        bus_write(12'h008, 32'hFFFF_FFFE);
        bus_write(12'h004, 32'd1);
        idle(CPS);
        rd_model(12'h000, "R1 count near wrap");
        idle(3 * CPS);
        rd_lit(12'h014, 32'd1, "R5 match after wraparound");
        rd_model(12'h000, "R1 count after wrap");

        // unmapped and misaligned
        rd_lit(12'h040, 32'd0, "R9 unmapped reads zero");
        rd_lit(12'hFFC, 32'd0, "R9 top of window reads zero");
        rd_lit(12'h005, 32'd0, "R9 misaligned reads zero");
        bus_write(12'h044, 32'hFFFF_FFFF);
        bus_write(12'h006, 32'h1234_5678);
        rd_lit(12'h004, 32'd1, "R9 alarm untouched by stray writes");

        // mask off drops irq, then equal-on-write fires immediately
        bus_write(12'h010, 32'd0);
        rd_lit(12'h018, 32'd0, "R6 masked cleared by mask off");
        bus_write(12'h01C, 32'd1);
        bus_write(12'h004, 32'd50);
        bus_write(12'h008, 32'd50);
        bus_write(12'h010, 32'd1);
        rd_lit(12'h014, 32'd1, "R4 preload rearms, equal fires");
        rd_model(12'h018, "R6 masked after rearm");
        idle(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule